// File: doc/BRIEF.md
# March Test Failure Reporter

This block sits beside a march-test engine for an embedded RAM and turns a plain pass/fail self-test into a diagnostic one. While diagnosis mode is enabled, every read compare strobe from the engine carries the expected word, the word that came back from the RAM, the address under test and the index of the current session (march element). When the two words differ, the block stalls the engine in that same cycle. It then raises an error flag and streams a failure record out on a single serial pin.

The record holds the failing address, then the session index, then the syndrome. The syndrome is the bitwise XOR of the expected and observed words, so a one marks every failing bit. A busy flag frames the serial bits. Once the stream is done, the block holds the engine stalled until the tester pulses a continue input. After that the march picks up where it stopped. When the engine reports that the whole test has finished, the block pulses an end-of-test output. Outside diagnosis mode, compare results pass through unreported.

Top module: `bisd_err_reporter`

## Requirements
- R1: After reset, err, stall, bef, bso and eop are all low.
- R2: A compare strobe whose expected and observed words are equal raises neither err nor stall nor bef.
- R3: A compare strobe with differing words while diag_en is high and no record is pending drives stall high in the same cycle. From the next clock edge it also drives err and bef high.
- R4: The record is REC_W = ADDR_W + SESS_W + DATA_W bits wide. From most significant to least significant, it is laid out as {fail_addr, session, exp_data XOR obs_data}, each field sampled at the failing strobe. Bit REC_W-1-i appears on bso during the i-th cycle after the failing strobe, counting from i = 0. bef is high for exactly those REC_W cycles.
- R5: After the last record bit, bef goes low. err and stall stay high for as long as cont stays low.
- R6: When cont is sampled high after the last record bit, err and stall go low at that clock edge. A cont pulse while bits are still shifting is ignored: the stream and the stall continue unchanged.
- R7: While diag_en is low, mismatching compare strobes are ignored: err, stall and bef stay low.
- R8: eop is high during the single cycle after each cycle in which test_done is high.
- R9: A cont pulse while no record is pending has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_en | input | 1 | Diagnosis mode enable |
| cmp_valid | input | 1 | Read compare strobe from the march engine |
| exp_data | input | DATA_W | Expected read word |
| obs_data | input | DATA_W | Word read from the RAM |
| fail_addr | input | ADDR_W | Address of the current read |
| session | input | SESS_W | Current session / march element index |
| test_done | input | 1 | Engine reports completion of the whole test |
| cont | input | 1 | Tester request to resume after a record |
| stall | output | 1 | Freezes the march engine |
| err | output | 1 | Failure pending |
| bso | output | 1 | Serial record output, MSB first |
| bef | output | 1 | High while record bits are on bso |
| eop | output | 1 | End-of-test pulse |

## Verification
stall is combinational: the bench checks it one nanosecond after driving a failing strobe, before the capturing edge. err and bef are registered, so they are checked just after the next edge. Record bit i is sampled just after the i-th edge following the capture. bef is expected low just after edge REC_W, and err and stall are expected low just after the edge that samples cont. eop is due one edge after test_done. Inputs change on falling edges and outputs are read 1 ns after rising edges, so every check falls in a known cycle.

// File: rtl/bisd_pkg.sv
package bisd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } diag_state_e;
endpackage

// File: rtl/bisd_rec_shifter.sv
module bisd_rec_shifter #(
  parameter int REC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift_en,
  input  logic [REC_W-1:0] rec_in,
  output logic             msb
);
  logic [REC_W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (load)          sreg_d = rec_in;
    else if (shift_en) sreg_d = {sreg_q[REC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sreg_q <= '0;
    else if (load || shift_en) sreg_q <= sreg_d;
  end

  assign msb = sreg_q[REC_W-1];
endmodule

// File: rtl/bisd_ctrl.sv
module bisd_ctrl
  import bisd_pkg::*;
#(
  parameter int REC_W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_hit,
  input  logic cont,
  output logic load,
  output logic shift_en,
  output logic busy,
  output logic shifting
);
  localparam int CNT_W = (REC_W > 1) ? $clog2(REC_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_W - 1);

  diag_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    load     = 1'b0;
    shift_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fail_hit) begin
          load    = 1'b1;
          cnt_d   = '0;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        shift_en = 1'b1;
        if (cnt_q == LAST) state_d = ST_HOLD;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_HOLD: begin
        if (cont) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign shifting = (state_q == ST_SHIFT);
endmodule

// File: rtl/bisd_err_reporter.sv
module bisd_err_reporter #(
  parameter int ADDR_W = 8,
  parameter int SESS_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              diag_en,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [DATA_W-1:0] obs_data,
  input  logic [ADDR_W-1:0] fail_addr,
  input  logic [SESS_W-1:0] session,
  input  logic              test_done,
  input  logic              cont,
  output logic              stall,
  output logic              err,
  output logic              bso,
  output logic              bef,
  output logic              eop
);
  localparam int REC_W = ADDR_W + SESS_W + DATA_W;

  logic [DATA_W-1:0] syndrome;
  logic              fail_hit, load, shift_en, busy, shifting;
  logic              eop_q;

  assign syndrome = exp_data ^ obs_data;
  assign fail_hit = diag_en && cmp_valid && (syndrome != '0) && !busy;

  bisd_ctrl #(.REC_W(REC_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fail_hit (fail_hit),
    .cont     (cont),
    .load     (load),
    .shift_en (shift_en),
    .busy     (busy),
    .shifting (shifting)
  );

  bisd_rec_shifter #(.REC_W(REC_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shift_en (shift_en),
    .rec_in   ({fail_addr, session, syndrome}),
    .msb      (bso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eop_q <= 1'b0;
    else        eop_q <= test_done;
  end

  assign eop   = eop_q;
  assign err   = busy;
  assign bef   = shifting;
  assign stall = busy || fail_hit;
endmodule

// File: rtl/bisd_err_reporter_chk.sv
module bisd_err_reporter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              diag_en,
  input logic              cmp_valid,
  input logic [DATA_W-1:0] exp_data,
  input logic [DATA_W-1:0] obs_data,
  input logic              test_done,
  input logic              cont,
  input logic              stall,
  input logic              err,
  input logic              bef,
  input logic              eop
);
  a_r3_fail_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_en && cmp_valid && (exp_data != obs_data) && !err) |=> (err && bef));

  a_r4_bef_under_err: assert property (@(posedge clk) disable iff (!rst_n)
    bef |-> (err && stall));

  a_r5_hold_until_cont: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !bef && !cont) |=> (err && stall && !bef));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !bef && cont) |=> !err);

  a_r7_nodiag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!diag_en && !err) |=> !err);

  a_r8_eop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |=> eop);
endmodule

bind bisd_err_reporter bisd_err_reporter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .diag_en   (diag_en),
  .cmp_valid (cmp_valid),
  .exp_data  (exp_data),
  .obs_data  (obs_data),
  .test_done (test_done),
  .cont      (cont),
  .stall     (stall),
  .err       (err),
  .bef       (bef),
  .eop       (eop)
);

// File: tb/tb_bisd_err_reporter.sv
`timescale 1ns/1ps
module tb_bisd_err_reporter;
  localparam int AW = 8, SW = 4, DW = 8;
  localparam int RW = AW + SW + DW;

  logic clk, rst_n, diag_en, cmp_valid, test_done, cont;
  logic [DW-1:0] exp_data, obs_data;
  logic [AW-1:0] fail_addr;
  logic [SW-1:0] session;
  logic stall, err, bso, bef, eop;

  int n_chk, n_fail;

  bisd_err_reporter #(.ADDR_W(AW), .SESS_W(SW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .diag_en(diag_en), .cmp_valid(cmp_valid),
    .exp_data(exp_data), .obs_data(obs_data), .fail_addr(fail_addr),
    .session(session), .test_done(test_done), .cont(cont),
    .stall(stall), .err(err), .bso(bso), .bef(bef), .eop(eop));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    diag_en = 0; cmp_valid = 0; test_done = 0; cont = 0;
    exp_data = '0; obs_data = '0; fail_addr = '0; session = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 err", err, 0); check("R1 stall", stall, 0);
    check("R1 bef", bef, 0); check("R1 bso", bso, 0); check("R1 eop", eop, 0);
    @(negedge clk); rst_n = 1;
    step();
  endtask

  task automatic t_match();
    @(negedge clk);
    diag_en = 1; cmp_valid = 1; exp_data = 8'h5A; obs_data = 8'h5A; fail_addr = 8'h10;
    #1 check("R2 stall", stall, 0);
    step();
    check("R2 err", err, 0); check("R2 bef", bef, 0);
    @(negedge clk); cmp_valid = 0;
  endtask

  task automatic t_nodiag();
    @(negedge clk);
    diag_en = 0; cmp_valid = 1; exp_data = 8'hFF; obs_data = 8'h00;
    #1 check("R7 stall", stall, 0);
    step();
    check("R7 err", err, 0); check("R7 bef", bef, 0);
    step();
    check("R7 err later", err, 0);
    @(negedge clk); cmp_valid = 0; diag_en = 1;
  endtask

  task automatic t_cont_idle();
    @(negedge clk); cont = 1;
    step();
    check("R9 err", err, 0); check("R9 stall", stall, 0); check("R9 bef", bef, 0);
    @(negedge clk); cont = 0;
  endtask

  task automatic t_fail(logic [AW-1:0] a, logic [SW-1:0] s,
                        logic [DW-1:0] e, logic [DW-1:0] o, bit cont_mid, int hold);
    logic [RW-1:0] expect_rec, got;
    expect_rec = {a, s, e ^ o};
    got = '0;
    @(negedge clk);
    diag_en = 1; cmp_valid = 1; fail_addr = a; session = s; exp_data = e; obs_data = o;
    #1 check("R3 stall same cycle", stall, 1);
    step();
    check("R3 err", err, 1);
    for (int i = 0; i < RW; i++) begin
      check("R4 bef high", bef, 1);
      if (i > 0) check("R6 stall during shift", stall, 1);
      got[RW-1-i] = bso;
      @(negedge clk);
      cmp_valid = 0;
      cont = (cont_mid && i == RW/2);
      step();
    end
    @(negedge clk); cont = 0;
    #1;
    check("R4 record", got, expect_rec);
    check("R5 bef low", bef, 0);
    check("R5 err held", err, 1);
    check("R5 stall held", stall, 1);
    repeat (hold) step();
    check("R5 err after hold", err, 1);
    @(negedge clk); cont = 1;
    step();
    check("R6 err released", err, 0);
    check("R6 stall released", stall, 0);
    @(negedge clk); cont = 0;
  endtask

  task automatic t_eop();
    @(negedge clk); test_done = 1;
    #1 check("R8 eop not early", eop, 0);
    step();
    check("R8 eop", eop, 1);
    @(negedge clk); test_done = 0;
    step();
    check("R8 eop single", eop, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_match();
    t_nodiag();
    t_cont_idle();
    t_fail(8'hA5, 4'h3, 8'hF0, 8'hF1, 0, 3);
    t_fail(8'hFF, 4'hC, 8'h00, 8'hB6, 1, 0);
    t_fail(8'h01, 4'h0, 8'hAA, 8'h55, 0, 5);
    t_eop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule